// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block models the command interface of a word-wide parallel NOR flash. It watches the chip-select, write-strobe and output-enable strobes, the address bus and the data bus. It recognises the unlock-protected command sequences for word program, sector erase, block erase and whole-array erase. It then runs a timed internal busy period on a small on-chip array. All strobes are active low and already synchronous to `clk`.

A bus write spans the interval in which both chip-select and write-strobe are low. The address is taken when that interval opens and the data when it closes. After a full sequence, the sequencer starts an internal operation that lasts a fixed number of clock cycles. Until it ends, reads return status bits and every write is dropped. Once it completes, the array is updated.

Reads return array contents one cycle after chip-select and output-enable are both seen low. The output-enable towards the pad is low at every other time. Address bits above the array width alias onto the array.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset every array word reads all ones, `dq_en` is low and the sequencer waits for the first unlock cycle.
- R2: A write happens only while `ce_n` and `we_n` are both low. Its address is the one present when that overlap begins. Its data is the one present when the overlap ends. A `we_n` pulse with `ce_n` high does nothing.
- R3: Word program is AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h, then a fourth write carrying the target address and data. Unlock addresses compare address bits [14:0] only, and command values compare data bits [7:0] only. The target word becomes the bitwise AND of its old value and the written data.
- R4: Sector erase is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address. Every word whose index matches that address above bit SECT_AW is set to all ones.
- R5: Block erase is the same five-cycle prefix followed by 50h at any address. Every word whose index matches that address above bit BLK_AW is set to all ones.
- R6: Chip erase is the same five-cycle prefix followed by 10h at 5555h. It sets every array word to all ones.
- R7: A write that does not match the next expected cycle returns the sequencer to idle and leaves the array unchanged. This includes 10h as the final cycle at an address other than 5555h.
- R8: An internal operation keeps the block busy for exactly PROG_CYC cycles (program) or ERASE_CYC cycles (any erase). The array changes only when that period ends. Writes issued while busy are ignored.
- R9: `dq_en` is high in a cycle exactly when `ce_n` and `oe_n` were both low at the previous clock edge. `dq_out` then carries the read result for the address sampled at that edge.
- R10: A read while busy returns a status word. Bit 7 is the complement of bit 7 of the data being programmed, or 0 during an erase. Bit 6 flips after every completed read access. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address bus |
| dq_in | input | DATA_W | Data bus into the block |
| dq_out | output | DATA_W | Read data or status word |
| dq_en | output | 1 | Drive enable for the data pad; low means high impedance |

## Verification
On every cycle, the assertions check four things: that the pad enable follows the read strobes, that no operation starts while one is running, that an operation starts only right after a captured write, and that the busy period has the exact length for its kind. The array contents are checked only by the bench scenarios. These cover the AND rule for programming, the region boundaries of sector and block erase, the address and data capture points on the composite strobe, and dropped or mismatched sequences. The bench also covers the polling and toggle bits seen while busy.

// File: rtl/flash_cmd_pkg.sv
// Shared types and command constants for the flash command sequencer.
// Assumes command bytes sit in data bits [7:0] and unlock addresses in [14:0].
package flash_cmd_pkg;
    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_KEY1  = 3'd1,
        SQ_KEY2  = 3'd2,
        SQ_WORD  = 3'd3,
        SQ_EKEY0 = 3'd4,
        SQ_EKEY1 = 3'd5,
        SQ_EKEY2 = 3'd6
    } seq_e;

    localparam logic [14:0] KEY_ADDR_A = 15'h5555;
    localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;
    localparam logic [7:0]  KEY_BYTE_A = 8'hAA;
    localparam logic [7:0]  KEY_BYTE_B = 8'h55;
    localparam logic [7:0]  CMD_WORD   = 8'hA0;
    localparam logic [7:0]  CMD_ERASE  = 8'h80;
    localparam logic [7:0]  CMD_SECT   = 8'h30;
    localparam logic [7:0]  CMD_BLK    = 8'h50;
    localparam logic [7:0]  CMD_CHIP   = 8'h10;
endpackage

// File: rtl/flash_bus_capture.sv
// Composite write-strobe capture.
// A write is the overlap of ce_n low and we_n low. The address is latched
// when the overlap starts and the data when it ends; a one-cycle pulse then
// presents both. Assumes the strobes are synchronous to clk.
module flash_bus_capture #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic wr_act;
    logic wr_prev;

    // Overlap of both active-low strobes.
    assign wr_act = ~ce_n & ~we_n;

    // Track the overlap edges and latch address at the start, data at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_prev  <= 1'b0;
            wr_pulse <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_prev  <= wr_act;
            wr_pulse <= wr_prev & ~wr_act;
            if (wr_act && !wr_prev) begin
                wr_addr <= addr;
            end
            if (wr_prev && !wr_act) begin
                wr_data <= dq_in;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_decode.sv
// Unlock-protected command sequence decoder.
// Walks the key cycles; a full sequence yields a one-cycle launch with the
// operation, target address and data. A mismatch returns to idle. Captured
// writes are ignored while the engine reports busy. Requires ADDR_W >= 15
// and DATA_W >= 8.
module flash_cmd_decode
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              launch,
    output op_e               launch_op,
    output logic [ADDR_W-1:0] launch_addr,
    output logic [DATA_W-1:0] launch_data
);
    seq_e        state;
    logic [14:0] key_addr;
    logic [7:0]  key_byte;
    logic        at_a;
    logic        at_b;

    // Fields compared against the unlock constants.
    assign key_addr = wr_addr[14:0];
    assign key_byte = wr_data[7:0];
    assign at_a     = (key_addr == KEY_ADDR_A);
    assign at_b     = (key_addr == KEY_ADDR_B);

    // Sequence state machine and launch generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SQ_IDLE;
            launch      <= 1'b0;
            launch_op   <= OP_PROG;
            launch_addr <= '0;
            launch_data <= '0;
        end else begin
            launch <= 1'b0;
            if (wr_pulse && !busy) begin
                launch_addr <= wr_addr;
                launch_data <= wr_data;
                unique case (state)
                    SQ_IDLE: begin
                        state <= (at_a && key_byte == KEY_BYTE_A) ? SQ_KEY1 : SQ_IDLE;
                    end
                    SQ_KEY1: begin
                        state <= (at_b && key_byte == KEY_BYTE_B) ? SQ_KEY2 : SQ_IDLE;
                    end
                    SQ_KEY2: begin
                        if (at_a && key_byte == CMD_WORD) begin
                            state <= SQ_WORD;
                        end else if (at_a && key_byte == CMD_ERASE) begin
                            state <= SQ_EKEY0;
                        end else begin
                            state <= SQ_IDLE;
                        end
                    end
                    SQ_WORD: begin
                        launch    <= 1'b1;
                        launch_op <= OP_PROG;
                        state     <= SQ_IDLE;
                    end
                    SQ_EKEY0: begin
                        state <= (at_a && key_byte == KEY_BYTE_A) ? SQ_EKEY1 : SQ_IDLE;
                    end
                    SQ_EKEY1: begin
                        state <= (at_b && key_byte == KEY_BYTE_B) ? SQ_EKEY2 : SQ_IDLE;
                    end
                    SQ_EKEY2: begin
                        state <= SQ_IDLE;
                        if (key_byte == CMD_SECT) begin
                            launch    <= 1'b1;
                            launch_op <= OP_SECT;
                        end else if (key_byte == CMD_BLK) begin
                            launch    <= 1'b1;
                            launch_op <= OP_BLK;
                        end else if (key_byte == CMD_CHIP && at_a) begin
                            launch    <= 1'b1;
                            launch_op <= OP_CHIP;
                        end
                    end
                    default: state <= SQ_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/flash_array_engine.sv
// Internal operation engine, storage array and read path.
// Runs a program or erase for a fixed cycle count and applies it to the
// array when the count expires. Reads return array data, or a status word
// while busy. Assumes launch never arrives while busy and DATA_W >= 8.
module flash_array_engine
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int ARR_AW    = 6,
    parameter int SECT_AW   = 11,
    parameter int BLK_AW    = 15,
    parameter int PROG_CYC  = 5000,
    parameter int ERASE_CYC = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  op_e               launch_op,
    input  logic [ADDR_W-1:0] launch_addr,
    input  logic [DATA_W-1:0] launch_data,
    input  logic              rd_act,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_en
);
    localparam int DEPTH = 1 << ARR_AW;
    localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    op_e               op_q;
    logic [ARR_AW-1:0] tgt_q;
    logic [DATA_W-1:0] dat_q;
    logic [CNT_W-1:0]  cnt;
    logic              finish;
    logic              tog;
    logic              rd_prev;
    logic [DEPTH-1:0]  hit;
    logic [DATA_W-1:0] status;

    // True when two indices agree on every bit at or above position sh.
    function automatic logic same_region(input logic [ARR_AW-1:0] a,
                                         input logic [ARR_AW-1:0] b,
                                         input int sh);
        return ((a ^ b) >> sh) == '0;
    endfunction

    assign finish = busy && (cnt == '0);

    // Per-word selection for the operation in flight.
    for (genvar w = 0; w < DEPTH; w++) begin : g_hit
        always_comb begin
            unique case (op_q)
                OP_PROG: hit[w] = (tgt_q == ARR_AW'(w));
                OP_SECT: hit[w] = same_region(ARR_AW'(w), tgt_q, SECT_AW);
                OP_BLK:  hit[w] = same_region(ARR_AW'(w), tgt_q, BLK_AW);
                default: hit[w] = 1'b1;
            endcase
        end
    end

    // Status word: polling bit, toggle bit, zeros elsewhere.
    always_comb begin
        status    = '0;
        status[7] = (op_q == OP_PROG) ? ~dat_q[7] : 1'b0;
        status[6] = tog;
    end

    // Busy timer and operation registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            op_q  <= OP_PROG;
            tgt_q <= '0;
            dat_q <= '0;
        end else if (launch && !busy) begin
            busy  <= 1'b1;
            cnt   <= (launch_op == OP_PROG) ? CNT_W'(PROG_CYC - 1) : CNT_W'(ERASE_CYC - 1);
            op_q  <= launch_op;
            tgt_q <= launch_addr[ARR_AW-1:0];
            dat_q <= launch_data;
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Array storage: erased at reset, updated when an operation finishes.
    always_ff @(posedge clk) begin
        for (int w = 0; w < DEPTH; w++) begin
            if (!rst_n) begin
                mem[w] <= '1;
            end else if (finish && hit[w]) begin
                mem[w] <= (op_q == OP_PROG) ? (mem[w] & dat_q) : '1;
            end
        end
    end

    // Read path with one-cycle latency, toggle bit flips at end of each busy read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_en   <= 1'b0;
            dq_out  <= '0;
            tog     <= 1'b0;
            rd_prev <= 1'b0;
        end else begin
            rd_prev <= rd_act;
            dq_en   <= rd_act;
            if (rd_act) begin
                dq_out <= busy ? status : mem[rd_addr[ARR_AW-1:0]];
            end else begin
                dq_out <= '0;
            end
            if (busy && rd_prev && !rd_act) begin
                tog <= ~tog;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
// Top of the parallel flash command sequencer.
// Connects strobe capture, sequence decoder and array engine. Reads are
// active when ce_n and oe_n are both low. Parameters size the array, its
// erase regions and the busy durations.
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int ARR_AW    = 6,
    parameter int SECT_AW   = 11,
    parameter int BLK_AW    = 15,
    parameter int PROG_CYC  = 5000,
    parameter int ERASE_CYC = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_en
);
    logic              wr_pulse;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              launch;
    op_e               launch_op;
    logic [ADDR_W-1:0] launch_addr;
    logic [DATA_W-1:0] launch_data;
    logic              busy;
    logic              rd_act;

    // Read access is the overlap of chip select and output enable.
    assign rd_act = ~ce_n & ~oe_n;

    flash_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .addr     (addr),
        .dq_in    (dq_in),
        .wr_pulse (wr_pulse),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    flash_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_pulse    (wr_pulse),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .busy        (busy),
        .launch      (launch),
        .launch_op   (launch_op),
        .launch_addr (launch_addr),
        .launch_data (launch_data)
    );

    flash_array_engine #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .ARR_AW    (ARR_AW),
        .SECT_AW   (SECT_AW),
        .BLK_AW    (BLK_AW),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_op   (launch_op),
        .launch_addr (launch_addr),
        .launch_data (launch_data),
        .rd_act      (rd_act),
        .rd_addr     (addr),
        .busy        (busy),
        .dq_out      (dq_out),
        .dq_en       (dq_en)
    );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
// Protocol checker for flash_cmd_seq, attached with bind.
// Watches the read strobes against the pad enable, the launch handshake
// between decoder and engine, and the length of each busy period.
module flash_cmd_seq_chk
    import flash_cmd_pkg::*;
#(
    parameter int PROG_CYC  = 5000,
    parameter int ERASE_CYC = 20000
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic oe_n,
    input logic dq_en,
    input logic wr_pulse,
    input logic launch,
    input op_e  launch_op,
    input logic busy
);
    int run_len;
    int exp_len;

    // Count busy cycles and remember the expected length of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= 0;
            exp_len <= 0;
        end else begin
            run_len <= busy ? run_len + 1 : 0;
            if (launch) begin
                exp_len <= (launch_op == OP_PROG) ? PROG_CYC : ERASE_CYC;
            end
        end
    end

    // R9: selected read drives the pad next cycle.
    a_r9_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n) |=> dq_en);

    // R9: no read strobe, no drive.
    a_r9_float_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |=> !dq_en);

    // R8: no new operation starts while one is running.
    a_r8_no_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy);

    // R3: an operation starts only right after a captured write.
    a_r3_launch_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> $past(wr_pulse));

    // R8: each busy period lasts exactly its configured count.
    a_r8_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == exp_len));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .dq_en     (dq_en),
    .wr_pulse  (wr_pulse),
    .launch    (launch),
    .launch_op (launch_op),
    .busy      (busy)
);

// File: tb/tb_flash_cmd_seq.sv
// Bench: small array (64 words, 8-word sectors, 32-word blocks), full sweeps
// with a word-by-word model of the array kept in the bench.
module tb_flash_cmd_seq;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int ARR_AW = 6;
    localparam int N = 1 << ARR_AW;
    localparam int SECT_AW = 3;
    localparam int BLK_AW = 5;
    localparam int PROG_CYC = 24;
    localparam int ERASE_CYC = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic dq_en;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [N];

    always #2 clk = ~clk;

    flash_cmd_seq #(
        .ADDR_W(AW), .DATA_W(DW), .ARR_AW(ARR_AW), .SECT_AW(SECT_AW),
        .BLK_AW(BLK_AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_en(dq_en)
    );

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Real write: address moved after the overlap opens, data settles before it closes.
    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); ce_n = 1'b0; addr = a; dq_in = ~d;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); addr = a ^ 16'h0001; dq_in = d;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1; addr = '0;
        repeat (3) @(negedge clk);
    endtask

    // Write strobe with chip select high.
    task automatic ghost_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); addr = a; dq_in = d; we_n = 1'b0;
        repeat (2) @(negedge clk); we_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic en);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
        @(negedge clk); d = dq_out; en = dq_en;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (ERASE_CYC + 10) @(negedge clk);
    endtask

    task automatic prog_seq(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_write(16'h5555, 16'h00AA);
        bus_write(16'h2AAA, 16'h0055);
        bus_write(16'h5555, 16'h00A0);
        bus_write(a, d);
    endtask

    task automatic erase_seq(input logic [AW-1:0] a, input logic [7:0] cmd);
        bus_write(16'h5555, 16'h00AA);
        bus_write(16'h2AAA, 16'h0055);
        bus_write(16'h5555, 16'h0080);
        bus_write(16'h5555, 16'h00AA);
        bus_write(16'h2AAA, 16'h0055);
        bus_write(a, {8'h00, cmd});
    endtask

    task automatic verify_all(input string req);
        logic [DW-1:0] d;
        logic en;
        for (int i = 0; i < N; i++) begin
            bus_read(AW'(i), d, en);
            check(req, d, model[i]);
        end
    endtask

    function automatic logic [DW-1:0] pat_a(input int i);
        return DW'(i * 16'h0101) ^ 16'hC3A5;
    endfunction

    function automatic logic [DW-1:0] pat_b(input int i);
        return DW'(i * 16'h2F13) ^ 16'h7E5B;
    endfunction

    logic done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d, s1, s2;
        logic en;
        for (int i = 0; i < N; i++) model[i] = '1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 dq_en", DW'(dq_en), '0);
        bus_read(16'h0000, d, en); check("R1 word0", d, 16'hFFFF);
        bus_read(AW'(N - 1), d, en); check("R1 last", d, 16'hFFFF);

        // R9: chip selected but output disabled -> no drive
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk); check("R9 oe high", DW'(dq_en), '0);
        ce_n = 1'b1;
        @(negedge clk); oe_n = 1'b0;
        @(negedge clk); check("R9 ce high", DW'(dq_en), '0);
        oe_n = 1'b1;
        bus_read(16'h0003, d, en); check("R9 enable", DW'(en), 16'h0001);

        // R2: ghost first key then real rest -> nothing programmed
        ghost_write(16'h5555, 16'h00AA);
        bus_write(16'h2AAA, 16'h0055);
        bus_write(16'h5555, 16'h00A0);
        bus_write(16'h0009, 16'h0000);
        settle();
        bus_read(16'h0009, d, en); check("R2 ghost", d, model[9]);

        // R3 + R2: sweep program of every word (address captured at overlap start)
        for (int i = 0; i < N; i++) begin
            prog_seq(AW'(i), pat_a(i));
            model[i] = model[i] & pat_a(i);
            repeat (PROG_CYC + 8) @(negedge clk);
        end
        verify_all("R3 program sweep");

        // R3: second pass, bits only clear
        for (int i = 0; i < N; i++) begin
            prog_seq(AW'(i) | 16'h8000, pat_b(i));
            model[i] = model[i] & pat_b(i);
            repeat (PROG_CYC + 8) @(negedge clk);
        end
        verify_all("R3 and sweep");

        // R4: sector erase, sector holding index 19 -> words 16..23
        erase_seq(16'h0013, 8'h30);
        for (int i = 0; i < N; i++) if ((i >> SECT_AW) == (19 >> SECT_AW)) model[i] = '1;
        settle();
        verify_all("R4 sector erase");

        // R5: block erase, block holding index 33 -> words 32..63
        erase_seq(16'h0021, 8'h50);
        for (int i = 0; i < N; i++) if ((i >> BLK_AW) == (33 >> BLK_AW)) model[i] = '1;
        settle();
        verify_all("R5 block erase");

        // R7: chip-erase command at wrong address -> ignored
        erase_seq(16'h1234, 8'h10);
        settle();
        verify_all("R7 chip bad addr");

        // R7: broken unlock, then a data write -> no change
        bus_write(16'h5555, 16'h00AA);
        bus_write(16'h2AAA, 16'h0055);
        bus_write(16'h5555, 16'h0077);
        bus_write(16'h0007, 16'h0000);
        settle();
        bus_read(16'h0007, d, en); check("R7 mismatch", d, model[7]);

        // R10: status during program: bit7 = ~data bit7, bit6 toggles, rest zero
        prog_seq(16'h0002, 16'h0080);
        bus_read(16'h0002, s1, en);
        bus_read(16'h0002, s2, en);
        check("R10 poll bit", DW'(s1[7]), 16'h0000);
        check("R10 zeros", s1 & 16'hFF3F, 16'h0000);
        check("R10 toggle", DW'(s1[6] ^ s2[6]), 16'h0001);
        model[2] = model[2] & 16'h0080;
        repeat (PROG_CYC + 8) @(negedge clk);
        bus_read(16'h0002, d, en); check("R8 program done", d, model[2]);

        // R8: writes during erase ignored; R10 erase status bit7 = 0
        erase_seq(16'h0000, 8'h30);
        bus_read(16'h0004, s1, en);
        check("R10 erase poll", DW'(s1[7]), 16'h0000);
        prog_seq(16'h0028, 16'h0000);
        for (int i = 0; i < 8; i++) model[i] = '1;
        settle();
        verify_all("R8 busy ignore");

        // R6: chip erase
        erase_seq(16'h5555, 8'h10);
        for (int i = 0; i < N; i++) model[i] = '1;
        settle();
        verify_all("R6 chip erase");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule